// File: doc/BRIEF.md
# Masked Interrupt Status Register Set

This block is a small register file that turns hardware event pulses into a single level-sensitive interrupt request. Each event input line sets a sticky bit in a status register. A mask register decides which of those bits may reach the interrupt pin. The output is high while at least one status bit is set and its mask bit is clear.

Software never writes the mask directly. A write to the enable alias unmasks every bit that carries a 1 in the write data. A write to the disable alias masks every such bit. Both aliases hold no storage. Software acknowledges an event by writing a 1 to its status bit.

All accesses are aligned 32-bit words on a plain register bus. A write is a single-cycle strobe. Read data is returned combinationally from the address. The number of implemented sources is a parameter, and bits above it read as zero.

Top module: `irq_mask_regs`

## Requirements
- R1: `irq` is high exactly when some status bit is 1 while the mask bit at the same position is 0. It reflects register state and changes right after the clock edge that updates status or mask.
- R2: A write to the status register (byte offset 0x00) clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R3: After reset, status reads 0, every implemented mask bit reads 1 (bit 0 included), and `irq` is 0.
- R4: An `eventIn` bit that is high at a clock edge sets the matching status bit. When an event and a write-1-to-clear hit the same bit in the same cycle, the event wins and the bit stays 1.
- R5: The mask register (byte offset 0x04) reads back the current mask. A bus write to offset 0x04 leaves the mask unchanged.
- R6: A write to the enable alias (byte offset 0x08) clears each mask bit whose write-data bit is 1. Every other mask bit keeps its value.
- R7: A write to the disable alias (byte offset 0x0C) sets each mask bit whose write-data bit is 1. Every other mask bit keeps its value.
- R8: Reads of the enable and disable aliases return 0.
- R9: Accesses are ignored in two cases: an address with bits [1:0] not equal to 0, and an aligned address at 0x10 or above. Writes there change no state, and reads there return 0.
- R10: Status and mask bits at positions NUM_SRC and above always read as 0. With the default NUM_SRC = 4, these are bits 31:4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Byte address of the access |
| wrEn | input | 1 | Write strobe, one write per cycle it is high |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr`, combinational |
| eventIn | input | NUM_SRC | Hardware event lines, one per status bit |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume that the inputs are synchronous to `clk` and that each write lasts exactly one cycle. They also assume that write data and event lines are stable across the edge that samples them. The stimulus changes every input only on the falling edge and holds `wrEn` for a single cycle. This means each write and each event pulse lands on exactly one rising edge. During reset the bench keeps `wrEn` and `eventIn` low, so the first cycle after reset has no past activity to check.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

  // Word indices of the mapped registers (byte offset / 4)
  localparam int unsigned IDX_STATUS  = 0;
  localparam int unsigned IDX_MASK    = 1;
  localparam int unsigned IDX_ENABLE  = 2;
  localparam int unsigned IDX_DISABLE = 3;

  // Write strobes from the decoder to the register datapath
  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic wrDisable;
  } ctrlStrobes_t;

  // Read source selection
  typedef enum logic [1:0] {
    SEL_ZERO   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2
  } rdSel_e;

endpackage

// File: rtl/irq_regs_ctrl.sv
module irq_regs_ctrl
  import irq_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output ctrlStrobes_t      strobes,
  output rdSel_e            rdSel
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             isAligned;
  logic [IDX_W-1:0] wordIdx;
  logic             hitStatus;
  logic             hitMask;
  logic             hitEnable;
  logic             hitDisable;

  assign isAligned  = (addr[1:0] == 2'b00);
  assign wordIdx    = addr[ADDR_W-1:2];
  assign hitStatus  = isAligned && (wordIdx == IDX_W'(IDX_STATUS));
  assign hitMask    = isAligned && (wordIdx == IDX_W'(IDX_MASK));
  assign hitEnable  = isAligned && (wordIdx == IDX_W'(IDX_ENABLE));
  assign hitDisable = isAligned && (wordIdx == IDX_W'(IDX_DISABLE));

  always_comb begin
    strobes.wrStatus  = wrEn && hitStatus;
    strobes.wrEnable  = wrEn && hitEnable;
    strobes.wrDisable = wrEn && hitDisable;
  end

  always_comb begin
    if (hitStatus)    rdSel = SEL_STATUS;
    else if (hitMask) rdSel = SEL_MASK;
    else              rdSel = SEL_ZERO;
  end

endmodule

// File: rtl/irq_regs_dp.sv
module irq_regs_dp
  import irq_regs_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  rdSel_e             rdSel,
  input  logic [NUM_SRC-1:0] wrBits,
  input  logic [NUM_SRC-1:0] eventIn,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic               irq
);

  logic [NUM_SRC-1:0] clrBits;
  logic [NUM_SRC-1:0] statusNext;
  logic [NUM_SRC-1:0] maskNext;

  assign clrBits = strobes.wrStatus ? wrBits : '0;

  // Per-bit update: the event input overrides a simultaneous clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_comb begin
      statusNext[i] = eventIn[i] | (statusQ[i] & ~clrBits[i]);
      if (strobes.wrDisable && wrBits[i])     maskNext[i] = 1'b1;
      else if (strobes.wrEnable && wrBits[i]) maskNext[i] = 1'b0;
      else                                    maskNext[i] = maskQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '1;
    end else begin
      statusQ <= statusNext;
      maskQ   <= maskNext;
    end
  end

  assign irq = |(statusQ & ~maskQ);

  always_comb begin
    rdData = '0;
    case (rdSel)
      SEL_STATUS: rdData[NUM_SRC-1:0] = statusQ;
      SEL_MASK:   rdData[NUM_SRC-1:0] = maskQ;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_regs_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] eventIn,
  output logic               irq
);

  ctrlStrobes_t       strobes;
  rdSel_e             rdSel;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;

  if (NUM_SRC < DATA_W) begin : g_hi
    logic unusedWrHi;
    assign unusedWrHi = ^wrData[DATA_W-1:NUM_SRC];
  end

  irq_regs_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .addr    (addr),
    .wrEn    (wrEn),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  irq_regs_dp #(
    .DATA_W  (DATA_W),
    .NUM_SRC (NUM_SRC)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdSel   (rdSel),
    .wrBits  (wrData[NUM_SRC-1:0]),
    .eventIn (eventIn),
    .rdData  (rdData),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .irq     (irq)
  );

endmodule

// File: rtl/irq_mask_regs_chk.sv
module irq_mask_regs_chk #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_SRC = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  addr,
  input logic               wrEn,
  input logic [NUM_SRC-1:0] wrLo,
  input logic [NUM_SRC-1:0] eventIn,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic               irq
);

  logic wrSt;
  logic wrEnb;
  logic wrDis;

  assign wrSt  = wrEn && (addr == ADDR_W'(8'h00));
  assign wrEnb = wrEn && (addr == ADDR_W'(8'h08));
  assign wrDis = wrEn && (addr == ADDR_W'(8'h0C));

  // R2
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrSt |=> ((statusQ & $past(wrLo) & ~$past(eventIn)) == '0));

  // R4
  event_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventIn != '0) |=> ((statusQ & $past(eventIn)) == $past(eventIn)));

  // R6
  enable_unmasks_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEnb |=> ((maskQ & $past(wrLo)) == '0));

  // R7
  disable_masks_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrDis |=> ((maskQ & $past(wrLo)) == $past(wrLo)));

  // R5
  mask_only_via_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEnb || wrDis) |=> $stable(maskQ));

  // R1
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past((eventIn != '0) || wrEnb));

  // R2
  status_no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ)) != '0) |-> $past(eventIn != '0));

endmodule

bind irq_mask_regs irq_mask_regs_chk #(
  .ADDR_W  (ADDR_W),
  .NUM_SRC (NUM_SRC)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .addr    (addr),
  .wrEn    (wrEn),
  .wrLo    (wrData[NUM_SRC-1:0]),
  .eventIn (eventIn),
  .statusQ (statusQ),
  .maskQ   (maskQ),
  .irq     (irq)
);

// File: tb/irq_mask_regs_tb.sv
`timescale 1ns/1ps
module irq_mask_regs_tb;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned NUM_SRC = 4;

  typedef struct {
    logic        isIrq;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic               wrEn = 1'b0;
  logic [DATA_W-1:0]  wrData = '0;
  logic [DATA_W-1:0]  rdData;
  logic [NUM_SRC-1:0] eventIn = '0;
  logic               irq;

  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  item_t       expQ[$];
  event        sampleEv;
  logic [3:0]  mSt;
  logic [3:0]  mMk;

  always #2 clk = ~clk;

  irq_mask_regs #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NUM_SRC (NUM_SRC)
  ) u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .rdData  (rdData),
    .eventIn (eventIn),
    .irq     (irq)
  );

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        act = it.isIrq ? {31'd0, irq} : rdData;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
        end
      end
    end
  end

  function automatic logic [31:0] modelRead(logic [ADDR_W-1:0] a);
    if (a == 8'h00) return {28'd0, mSt};
    if (a == 8'h04) return {28'd0, mMk};
    return 32'd0;
  endfunction

  // One bus cycle with optional write and events; updates the model
  task automatic cycle(input logic w, input logic [ADDR_W-1:0] a,
                       input logic [31:0] d, input logic [3:0] ev);
    @(negedge clk);
    addr = a; wrEn = w; wrData = d; eventIn = ev;
    @(negedge clk);
    wrEn = 1'b0; eventIn = '0;
    if (w && a == 8'h00) mSt = mSt & ~d[3:0];
    if (w && a == 8'h08) mMk = mMk & ~d[3:0];
    if (w && a == 8'h0C) mMk = mMk | d[3:0];
    mSt = mSt | ev;
  endtask

  task automatic readChk(input logic [ADDR_W-1:0] a, input string req);
    item_t it;
    addr = a;
    it.isIrq = 1'b0; it.exp = modelRead(a); it.req = req;
    expQ.push_back(it);
    #1 ->sampleEv;
    #0;
  endtask

  task automatic readExp(input logic [ADDR_W-1:0] a, input logic [31:0] e,
                         input string req);
    item_t it;
    addr = a;
    it.isIrq = 1'b0; it.exp = e; it.req = req;
    expQ.push_back(it);
    #1 ->sampleEv;
    #0;
  endtask

  task automatic irqChk(input string req);
    item_t it;
    it.isIrq = 1'b1; it.exp = {31'd0, |(mSt & ~mMk)}; it.req = req;
    expQ.push_back(it);
    #1 ->sampleEv;
    #0;
  endtask

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    mSt = 4'h0; mMk = 4'hF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R3 reset state
    readExp(8'h00, 32'h0, "R3 status");
    readExp(8'h04, 32'hF, "R3 mask");
    irqChk("R3 irq");

    // R4 events set status, masked so R1 keeps irq low
    cycle(1'b0, 8'h00, 32'h0, 4'b0101);
    readExp(8'h00, 32'h5, "R4 status set");
    irqChk("R1 masked");

    // R5 direct mask write ignored
    cycle(1'b1, 8'h04, 32'h0, 4'b0000);
    readExp(8'h04, 32'hF, "R5 mask unchanged");

    // R6 enable bit0
    cycle(1'b1, 8'h08, 32'h1, 4'b0000);
    readExp(8'h04, 32'hE, "R6 mask");
    irqChk("R1 unmasked");

    // R8 alias reads
    readExp(8'h08, 32'h0, "R8 enable read");
    readExp(8'h0C, 32'h0, "R8 disable read");

    // R2 clear bit2, then a zero write
    cycle(1'b1, 8'h00, 32'h4, 4'b0000);
    readExp(8'h00, 32'h1, "R2 w1c");
    cycle(1'b1, 8'h00, 32'h0, 4'b0000);
    readExp(8'h00, 32'h1, "R2 zero write");

    // R4 event wins over clear on the same bit
    cycle(1'b1, 8'h00, 32'h1, 4'b0001);
    readExp(8'h00, 32'h1, "R4 event wins");
    irqChk("R1 still set");

    cycle(1'b1, 8'h00, 32'h1, 4'b0000);
    readExp(8'h00, 32'h0, "R2 clear bit0");
    irqChk("R1 cleared");

    // R7 disable bit0, new event stays masked
    cycle(1'b1, 8'h0C, 32'h1, 4'b0000);
    readExp(8'h04, 32'hF, "R7 mask");
    cycle(1'b0, 8'h00, 32'h0, 4'b0001);
    irqChk("R7 irq masked");

    // R9 misaligned and unmapped accesses
    cycle(1'b1, 8'h01, 32'h1, 4'b0000);
    readExp(8'h00, 32'h1, "R9 misaligned write ignored");
    cycle(1'b1, 8'h09, 32'hF, 4'b0000);
    readExp(8'h04, 32'hF, "R9 misaligned enable ignored");
    cycle(1'b1, 8'h10, 32'hFFFF_FFFF, 4'b0000);
    readChk(8'h00, "R9 unmapped write status");
    readChk(8'h04, "R9 unmapped write mask");
    readExp(8'h10, 32'h0, "R9 unmapped read");
    readExp(8'h05, 32'h0, "R9 misaligned read");

    // R10 upper bits read zero
    cycle(1'b1, 8'h08, 32'hFFFF_FFFF, 4'b1111);
    readExp(8'h04, 32'h0, "R10 mask upper");
    readExp(8'h00, 32'hF, "R10 status upper");
    irqChk("R1 all sources");
    cycle(1'b1, 8'h0C, 32'hFFFF_FFFF, 4'b0000);
    readExp(8'h04, 32'hF, "R10 disable all");
    irqChk("R1 all masked");

    // R3 reset in the middle
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mSt = 4'h0; mMk = 4'hF;
    readExp(8'h00, 32'h0, "R3 status after reset");
    readExp(8'h04, 32'hF, "R3 mask after reset");

    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule